// File: doc/BRIEF.md
# Audio Frame Serial Port

This block is a master-mode serial audio port. While its enable input is high it produces a bit clock and a frame clock from the system clock, and it runs fixed 128-bit frames back to back. Each frame carries a left sample in its first half and a right sample in its second half. Outgoing samples come from two small transmit queues, one for each channel. Incoming samples, captured from the serial data input, are placed in two small receive queues.

Per-queue service flags and sticky error flags are collected into one status word. A single interrupt output combines the service flags, each gated by its own mask bit, with the error flags, which cannot be masked. Dropping the enable input stops the serial clocks at once, abandons the frame in progress and empties all four queues. The error flags and all configuration inputs keep their values.

Top module: `aud_frame_port`

## Requirements
- R1: After reset the port is stopped: `sclk` and `lrck` are 1, `sdout` is 0, all error flags are 0 and `status` reads 8'h03 (both transmit queues empty, both receive queues empty).
- R2: While `en` is low, `sclk` and `lrck` stay at 1 and do not toggle.
- R3: When `en` rises, the next clock edge drives `sclk` and `lrck` to 0 together to mark the start of a frame. After that, `sclk` toggles every `div_half` system clocks, and a `div_half` of 0 behaves as 1.
- R4: `lrck` changes only on the same system clock edge as an `sclk` edge in the same direction. At each rising `sclk` edge, `lrck` is 0 for frame bits 0 to 63 and 1 for bits 64 to 127.
- R5: Frames of 128 bits run with no gap between them. The left sample occupies bits 0 to 15 and the right sample occupies bits 64 to 79, each MSB first. All other bits are 0. `sdout` changes on falling `sclk` edges. `sdin` is sampled on rising edges, and the same bit positions are assembled into the receive queues.
- R6: Clearing `en` returns `sclk` and `lrck` to 1 on the next clock edge and abandons the frame in progress.
- R7: Clearing `en` empties all four queues. The error flags keep their values.
- R8: If a transmit queue is empty when its half frame starts, zeros are sent and the underrun flag is set (`status[4]` left, `status[5]` right). If a receive queue is full when a sample completes, that sample is dropped and the overrun flag is set (`status[6]` left, `status[7]` right).
- R9: Service flags: `status[0]`/`status[1]` are 1 when the left/right transmit queue holds 4 or fewer entries. `status[2]`/`status[3]` are 1 when the left/right receive queue holds 4 or more entries. Each queue is 8 entries deep.
- R10: `irq` is the OR of `status[3:0] & irq_mask` and all of `status[7:4]`. The mask changes no status bit.
- R11: Writing 1 to a bit of `err_clr` clears the matching error flag (`err_clr[k]` clears `status[4+k]`). Bits written as 0 leave their flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; clearing it aborts and flushes |
| div_half | input | DIV_W | Half period of `sclk` in system clocks |
| irq_mask | input | 4 | Per-service-flag interrupt enables |
| err_clr | input | 4 | Write-1-to-clear strobes for the error flags |
| tx_l_push | input | 1 | Push `tx_l_data` into the left transmit queue |
| tx_l_data | input | SAMPLE_W | Left sample to transmit |
| tx_r_push | input | 1 | Push `tx_r_data` into the right transmit queue |
| tx_r_data | input | SAMPLE_W | Right sample to transmit |
| rx_l_pop | input | 1 | Remove the head of the left receive queue |
| rx_l_data | output | SAMPLE_W | Head of the left receive queue |
| rx_r_pop | input | 1 | Remove the head of the right receive queue |
| rx_r_data | output | SAMPLE_W | Head of the right receive queue |
| status | output | 8 | {error flags[3:0], service flags[3:0]} |
| irq | output | 1 | Combined interrupt |
| sclk | output | 1 | Serial bit clock |
| lrck | output | 1 | Frame clock (0 = left half) |
| sdout | output | 1 | Serial data out |
| sdin | input | 1 | Serial data in |

## Verification
If the bit counter or the divider is wrong, the fault shows within one `sclk` period. It appears as a half period of the wrong length, or as an `lrck` level that does not match the bit index at a sampling edge. If a transmit head is loaded from the wrong queue, or the shift register is misaligned, the decoded frame on `sdout` is wrong within that same frame. With `sdout` looped back to `sdin`, the same fault also reaches the receive queue heads 21 bits later. Queue counts cannot be read directly, so a wrong occupancy is seen through the service flag thresholds. A flush that does not happen shows on the next clock after `en` falls.

// File: rtl/afp_pkg.sv
package afp_pkg;
   localparam int NCH = 2;
   localparam int CH_LEFT = 0;
   localparam int CH_RIGHT = 1;

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_RISE = 2'd1,
      EV_FALL = 2'd2
   } sclk_ev_e;
endpackage

// File: rtl/afp_fifo.sv
module afp_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       flush_i,
   input  logic                       push_i,
   input  logic [W-1:0]               wdata_i,
   input  logic                       pop_i,
   output logic [W-1:0]               rdata_o,
   output logic [$clog2(DEPTH+1)-1:0] count_o,
   output logic                       full_o,
   output logic                       empty_o
);
   localparam int AW  = $clog2(DEPTH);
   localparam int CNW = $clog2(DEPTH+1);
   localparam logic [CNW-1:0] CNT_MAX = CNW'(DEPTH);

   logic [W-1:0]   mem_q [DEPTH];
   logic [AW-1:0]  wr_q, rd_q;
   logic [CNW-1:0] cnt_q;
   logic           do_wr, do_rd;

   assign full_o  = (cnt_q == CNT_MAX);
   assign empty_o = (cnt_q == '0);
   assign count_o = cnt_q;
   assign rdata_o = mem_q[rd_q];
   assign do_wr   = push_i && !full_o && !flush_i;
   assign do_rd   = pop_i && !empty_o && !flush_i;

   always_ff @(posedge clk) begin
      if (do_wr) mem_q[wr_q] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else if (flush_i) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_wr) wr_q <= wr_q + AW'(1);
         if (do_rd) rd_q <= rd_q + AW'(1);
         case ({do_wr, do_rd})
            2'b10:   cnt_q <= cnt_q + CNW'(1);
            2'b01:   cnt_q <= cnt_q - CNW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> !full_o);
   // R8
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);
   // R7
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> empty_o);
   // R9
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_MAX);
endmodule

// File: rtl/afp_seq.sv
module afp_seq
   import afp_pkg::*;
#(
   parameter int SW = 16,
   parameter int HB = 64,
   parameter int DW = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en_i,
   input  logic [DW-1:0]           div_i,
   input  logic [NCH-1:0][SW-1:0]  head_i,
   input  logic [NCH-1:0]          empty_i,
   output logic [NCH-1:0]          pop_o,
   output logic [NCH-1:0]          under_o,
   output logic [NCH-1:0]          rxv_o,
   output logic [SW-1:0]           rxd_o,
   output logic                    flush_o,
   input  logic                    sdin_i,
   output logic                    sclk_o,
   output logic                    lrck_o,
   output logic                    sdout_o
);
   localparam int FB = 2 * HB;
   localparam int CW = $clog2(FB);
   localparam int PW = $clog2(HB);
   localparam logic [PW-1:0] LAST  = PW'(SW - 1);
   localparam logic [CW-1:0] RSTRT = CW'(HB);
   localparam logic [DW-1:0] ONE   = DW'(1);

   logic          run_q, sclk_q, lrck_q;
   logic [DW-1:0] div_q, lim;
   logic [CW-1:0] bit_q, bit_n;
   logic [PW-1:0] pos, pos_n;
   logic          half, half_n;
   logic [SW-1:0] txw_q, rxs_q, rx_word, ld_word;
   logic          start, tick, load, ld_ch;
   sclk_ev_e      ev;

   always_comb begin
      lim     = (div_i == '0) ? ONE : div_i;
      start   = en_i && !run_q;
      tick    = run_q && en_i && (div_q >= lim - ONE);
      ev      = EV_NONE;
      if (tick) ev = sclk_q ? EV_FALL : EV_RISE;
      bit_n   = bit_q + CW'(1);
      pos     = bit_q[PW-1:0];
      half    = bit_q[CW-1];
      pos_n   = bit_n[PW-1:0];
      half_n  = bit_n[CW-1];
      load    = start || (ev == EV_FALL && pos_n == '0);
      ld_ch   = start ? 1'b0 : half_n;
      ld_word = empty_i[ld_ch] ? '0 : head_i[ld_ch];
      rx_word = {rxs_q[SW-2:0], sdin_i};
      for (int c = 0; c < NCH; c++) begin
         pop_o[c]   = load && (int'(ld_ch) == c) && !empty_i[c];
         under_o[c] = load && (int'(ld_ch) == c) && empty_i[c];
         rxv_o[c]   = (ev == EV_RISE) && (pos == LAST) && (int'(half) == c);
      end
   end

   assign rxd_o   = rx_word;
   assign flush_o = run_q && !en_i;
   assign sclk_o  = sclk_q;
   assign lrck_o  = lrck_q;
   assign sdout_o = run_q && (pos <= LAST) && txw_q[SW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         sclk_q <= 1'b1;
         lrck_q <= 1'b1;
         div_q  <= '0;
         bit_q  <= '0;
         txw_q  <= '0;
         rxs_q  <= '0;
      end else if (!en_i) begin
         run_q  <= 1'b0;
         sclk_q <= 1'b1;
         lrck_q <= 1'b1;
         div_q  <= '0;
         bit_q  <= '0;
         txw_q  <= '0;
      end else if (start) begin
         run_q  <= 1'b1;
         sclk_q <= 1'b0;
         lrck_q <= 1'b0;
         div_q  <= '0;
         bit_q  <= '0;
         txw_q  <= ld_word;
      end else if (tick) begin
         div_q  <= '0;
         sclk_q <= !sclk_q;
         if (ev == EV_RISE) begin
            if (pos <= LAST) rxs_q <= rx_word;
            if (bit_q == RSTRT) lrck_q <= 1'b1;
         end else begin
            bit_q <= bit_n;
            if (bit_n == '0) lrck_q <= 1'b0;
            txw_q <= (pos_n == '0) ? ld_word : (txw_q << 1);
         end
      end else begin
         div_q <= div_q + ONE;
      end
   end

   // R2
   idle_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> (sclk_q && lrck_q && !sdout_o));
   // R3
   start_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && !run_q) |=> (run_q && !sclk_q && !lrck_q));
   // R4
   lrck_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(lrck_q) && run_q) |-> $rose(sclk_q));
   // R4
   lrck_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lrck_q) |-> $fell(sclk_q));
   // R6
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !en_i) |=> (!run_q && sclk_q && lrck_q));
   // R8
   one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pop_o | under_o));
endmodule

// File: rtl/afp_irq.sv
module afp_irq
   import afp_pkg::*;
#(
   parameter int CNW    = 4,
   parameter int TX_THR = 4,
   parameter int RX_THR = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NCH-1:0][CNW-1:0]  tx_cnt_i,
   input  logic [NCH-1:0][CNW-1:0]  rx_cnt_i,
   input  logic [NCH-1:0]           under_i,
   input  logic [NCH-1:0]           over_i,
   input  logic [2*NCH-1:0]         clr_i,
   input  logic [2*NCH-1:0]         mask_i,
   output logic [4*NCH-1:0]         status_o,
   output logic                     irq_o
);
   logic [2*NCH-1:0] svc, err_q, set;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_svc
         assign svc[c]       = (tx_cnt_i[c] <= CNW'(TX_THR));
         assign svc[NCH + c] = (rx_cnt_i[c] >= CNW'(RX_THR));
      end
   endgenerate

   assign set = {over_i, under_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= '0;
      else        err_q <= (err_q & ~clr_i) | set;
   end

   assign status_o = {err_q, svc};
   assign irq_o    = (|(svc & mask_i)) || (|err_q);

   generate
      for (genvar b = 0; b < 2*NCH; b++) begin : g_err_chk
         // R11
         err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[b] && !set[b]) |=> !status_o[2*NCH + b]);
         // R8
         err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set[b] |=> status_o[2*NCH + b]);
      end
   endgenerate

   // R10
   irq_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|status_o[4*NCH-1:2*NCH]) |-> irq_o);
endmodule

// File: rtl/aud_frame_port.sv
module aud_frame_port
   import afp_pkg::*;
#(
   parameter int SAMPLE_W   = 16,
   parameter int HALF_BITS  = 64,
   parameter int FIFO_DEPTH = 8,
   parameter int TX_THR     = 4,
   parameter int RX_THR     = 4,
   parameter int DIV_W      = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic [DIV_W-1:0]     div_half,
   input  logic [2*NCH-1:0]     irq_mask,
   input  logic [2*NCH-1:0]     err_clr,
   input  logic                 tx_l_push,
   input  logic [SAMPLE_W-1:0]  tx_l_data,
   input  logic                 tx_r_push,
   input  logic [SAMPLE_W-1:0]  tx_r_data,
   input  logic                 rx_l_pop,
   output logic [SAMPLE_W-1:0]  rx_l_data,
   input  logic                 rx_r_pop,
   output logic [SAMPLE_W-1:0]  rx_r_data,
   output logic [4*NCH-1:0]     status,
   output logic                 irq,
   output logic                 sclk,
   output logic                 lrck,
   output logic                 sdout,
   input  logic                 sdin
);
   localparam int CNW = $clog2(FIFO_DEPTH + 1);

   generate
      if (SAMPLE_W < 2 || SAMPLE_W > HALF_BITS) begin : g_bad_sw
         $error("SAMPLE_W must lie in 2..HALF_BITS");
      end
      if (HALF_BITS < 2 || (HALF_BITS & (HALF_BITS - 1)) != 0) begin : g_bad_hb
         $error("HALF_BITS must be a power of two");
      end
      if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_dp
         $error("FIFO_DEPTH must be a power of two");
      end
      if (TX_THR > FIFO_DEPTH || RX_THR > FIFO_DEPTH) begin : g_bad_thr
         $error("thresholds exceed FIFO_DEPTH");
      end
   endgenerate

   logic [NCH-1:0]                tx_push_a, rx_pop_a;
   logic [NCH-1:0][SAMPLE_W-1:0]  tx_data_a, tx_head, rx_head;
   logic [NCH-1:0][CNW-1:0]       tx_cnt, rx_cnt;
   logic [NCH-1:0]                tx_full, tx_empty, rx_full, rx_empty;
   logic [NCH-1:0]                seq_pop, seq_under, seq_rxv, rx_over;
   logic [SAMPLE_W-1:0]           seq_rxd;
   logic                          flush;

   assign tx_push_a = {tx_r_push, tx_l_push};
   assign tx_data_a = {tx_r_data, tx_l_data};
   assign rx_pop_a  = {rx_r_pop, rx_l_pop};
   assign rx_l_data = rx_head[CH_LEFT];
   assign rx_r_data = rx_head[CH_RIGHT];

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         afp_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_txq (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush_i (flush),
            .push_i  (tx_push_a[c] && !tx_full[c]),
            .wdata_i (tx_data_a[c]),
            .pop_i   (seq_pop[c]),
            .rdata_o (tx_head[c]),
            .count_o (tx_cnt[c]),
            .full_o  (tx_full[c]),
            .empty_o (tx_empty[c])
         );
         afp_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush_i (flush),
            .push_i  (seq_rxv[c] && !rx_full[c]),
            .wdata_i (seq_rxd),
            .pop_i   (rx_pop_a[c] && !rx_empty[c]),
            .rdata_o (rx_head[c]),
            .count_o (rx_cnt[c]),
            .full_o  (rx_full[c]),
            .empty_o (rx_empty[c])
         );
         assign rx_over[c] = seq_rxv[c] && rx_full[c];
      end
   endgenerate

   afp_seq #(.SW(SAMPLE_W), .HB(HALF_BITS), .DW(DIV_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en),
      .div_i   (div_half),
      .head_i  (tx_head),
      .empty_i (tx_empty),
      .pop_o   (seq_pop),
      .under_o (seq_under),
      .rxv_o   (seq_rxv),
      .rxd_o   (seq_rxd),
      .flush_o (flush),
      .sdin_i  (sdin),
      .sclk_o  (sclk),
      .lrck_o  (lrck),
      .sdout_o (sdout)
   );

   afp_irq #(.CNW(CNW), .TX_THR(TX_THR), .RX_THR(RX_THR)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_cnt_i (tx_cnt),
      .rx_cnt_i (rx_cnt),
      .under_i  (seq_under),
      .over_i   (rx_over),
      .clr_i    (err_clr),
      .mask_i   (irq_mask),
      .status_o (status),
      .irq_o    (irq)
   );

   // R7
   flush_keeps_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !(|seq_under) && !(|rx_over) && err_clr == '0)
         |=> $stable(status[4*NCH-1:2*NCH]));
endmodule

// File: tb/tb_aud_frame_port.sv
module tb_aud_frame_port;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 100000;

   logic        clk = 1'b0;
   logic        rst_n, en;
   logic [7:0]  div_half;
   logic [3:0]  irq_mask, err_clr;
   logic        tx_l_push, tx_r_push, rx_l_pop, rx_r_pop;
   logic [15:0] tx_l_data, tx_r_data, rx_l_data, rx_r_data;
   logic [7:0]  status;
   logic        irq, sclk, lrck, sdout, sdin;
   int          n_chk = 0;
   int          n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign sdin = sdout;

   aud_frame_port dut (
      .clk(clk), .rst_n(rst_n), .en(en), .div_half(div_half),
      .irq_mask(irq_mask), .err_clr(err_clr),
      .tx_l_push(tx_l_push), .tx_l_data(tx_l_data),
      .tx_r_push(tx_r_push), .tx_r_data(tx_r_data),
      .rx_l_pop(rx_l_pop), .rx_l_data(rx_l_data),
      .rx_r_pop(rx_r_pop), .rx_r_data(rx_r_data),
      .status(status), .irq(irq), .sclk(sclk), .lrck(lrck),
      .sdout(sdout), .sdin(sdin)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] smp(input int d, input int k, input bit right);
      logic [15:0] v;
      v = 16'h8001 + 16'(d * 16'h0F11) + 16'(k * 16'h2345);
      return right ? ~v : v;
   endfunction

   task automatic push_l(input logic [15:0] v);
      tx_l_data = v; tx_l_push = 1'b1;
      @(negedge clk);
      tx_l_push = 1'b0;
   endtask

   task automatic push_r(input logic [15:0] v);
      tx_r_data = v; tx_r_push = 1'b1;
      @(negedge clk);
      tx_r_push = 1'b0;
   endtask

   task automatic clear_errs();
      err_clr = 4'hF;
      @(negedge clk);
      err_clr = 4'h0;
   endtask

   task automatic run_div(input int d);
      int per, rises, cyc, last, nedge, aerr, perr, chg;
      logic ps, pl, s0, l0;
      logic [0:127] fb;
      per = (d == 0) ? 1 : d;
      rises = 0; cyc = 0; last = 0; nedge = 0; aerr = 0; perr = 0;
      fb = '0;
      div_half = 8'(d);
      for (int k = 0; k < 4; k++) begin
         push_l(smp(d, k, 1'b0));
         push_r(smp(d, k, 1'b1));
      end
      ps = sclk; pl = lrck;
      en = 1'b1;
      while (rises < 640) begin
         @(negedge clk);
         cyc++;
         rx_l_pop = 1'b0; rx_r_pop = 1'b0;
         if (lrck != pl && !(sclk != ps && sclk == lrck)) aerr++;
         if (sclk != ps) begin
            if (nedge > 0 && cyc - last != per) perr++;
            last = cyc;
            nedge++;
         end
         if (sclk && !ps) begin
            int r, f;
            logic [15:0] el, er;
            r = rises % 128;
            f = rises / 128;
            el = (f < 4) ? smp(d, f, 1'b0) : 16'h0;
            er = (f < 4) ? smp(d, f, 1'b1) : 16'h0;
            if (lrck != (r >= 64)) aerr++;
            fb[r] = sdout;
            if (r == 100) begin
               // R5 loopback through receive queues
               chk(rx_l_data == el, "R5 rx left", 64'(rx_l_data), 64'(el));
               chk(rx_r_data == er, "R5 rx right", 64'(rx_r_data), 64'(er));
               rx_l_pop = 1'b1; rx_r_pop = 1'b1;
            end
            if (r == 127) begin
               chk(fb[0:15] == el, "R5 tx left bits", 64'(fb[0:15]), 64'(el));
               chk(fb[64:79] == er, "R5 tx right bits", 64'(fb[64:79]), 64'(er));
               chk(fb[16:63] == '0 && fb[80:127] == '0, "R5 zero padding",
                   64'(fb[16:63]), 64'h0);
            end
            rises++;
         end
         ps = sclk; pl = lrck;
      end
      @(negedge clk);
      rx_l_pop = 1'b0; rx_r_pop = 1'b0;
      chk(aerr == 0, "R4 lrck alignment", 64'(aerr), 64'h0);
      chk(perr == 0, "R3 sclk half period", 64'(perr), 64'h0);
      // R8 both queues ran dry in frame 4
      chk(status[5:4] == 2'b11, "R8 underrun flags", 64'(status[5:4]), 64'h3);
      chk(irq == 1'b1, "R10 unmaskable error irq", 64'(irq), 64'h1);
      for (int k = 0; k < 6; k++) push_l(16'h1111);
      chk(status[0] == 1'b0, "R9 tx left above threshold", 64'(status[0]), 64'h0);
      en = 1'b0;
      @(negedge clk);
      chk(sclk && lrck, "R6 abort to idle", 64'({sclk, lrck}), 64'h3);
      s0 = sclk; l0 = lrck; chg = 0;
      repeat (20) begin
         @(negedge clk);
         if (sclk != s0 || lrck != l0) chg++;
      end
      chk(chg == 0, "R2 idle static", 64'(chg), 64'h0);
      chk(status[3:0] == 4'b0011, "R7 queues flushed", 64'(status[3:0]), 64'h3);
      chk(status[5:4] == 2'b11, "R7 errors retained", 64'(status[5:4]), 64'h3);
      clear_errs();
      chk(status == 8'h03, "R11 clear all errors", 64'(status), 64'h03);
      chk(irq == 1'b0, "R10 irq quiet", 64'(irq), 64'h0);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; en = 1'b0; div_half = 8'd1; irq_mask = 4'h0; err_clr = 4'h0;
      tx_l_push = 1'b0; tx_r_push = 1'b0; tx_l_data = '0; tx_r_data = '0;
      rx_l_pop = 1'b0; rx_r_pop = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(status == 8'h03, "R1 status", 64'(status), 64'h03);
      chk(sclk && lrck && !sdout, "R1 serial pins", 64'({sclk, lrck, sdout}), 64'h6);
      chk(irq == 1'b0, "R1 irq", 64'(irq), 64'h0);

      // R10 full mask sweep with only tx service flags set
      for (int m = 0; m < 16; m++) begin
         irq_mask = 4'(m);
         @(negedge clk);
         chk(irq == |(4'(m) & 4'b0011), "R10 mask sweep", 64'(irq), 64'(|(4'(m) & 4'b0011)));
         chk(status == 8'h03, "R10 mask leaves status", 64'(status), 64'h03);
      end
      irq_mask = 4'h0;

      // R9 left transmit threshold sweep
      for (int k = 1; k <= 8; k++) begin
         push_l(16'(k));
         chk(status[0] == (k <= 4), "R9 tx service threshold", 64'(status[0]), 64'(k <= 4));
      end

      // R3 start mark, R6/R7 one-cycle run then flush
      en = 1'b1;
      @(negedge clk);
      chk(!sclk && !lrck, "R3 start mark", 64'({sclk, lrck}), 64'h0);
      en = 1'b0;
      @(negedge clk);
      chk(sclk && lrck, "R6 immediate stop", 64'({sclk, lrck}), 64'h3);
      chk(status == 8'h03, "R7 flush after short run", 64'(status), 64'h03);

      for (int d = 0; d < 4; d++) run_div(d);

      // R8 overrun, R9 rx thresholds, R11 selective clear
      div_half = 8'd1;
      en = 1'b1;
      repeat (2700) @(negedge clk);
      chk(status[7:6] == 2'b11, "R8 overrun flags", 64'(status[7:6]), 64'h3);
      chk(status[3:2] == 2'b11, "R9 rx service set", 64'(status[3:2]), 64'h3);
      en = 1'b0;
      @(negedge clk);
      chk(status[3:2] == 2'b00, "R7 rx flushed", 64'(status[3:2]), 64'h0);
      chk(status[7:6] == 2'b11, "R7 overrun retained", 64'(status[7:6]), 64'h3);
      err_clr = 4'b0100;
      @(negedge clk);
      err_clr = 4'h0;
      chk(status[7:4] == 4'b1011, "R11 selective clear", 64'(status[7:4]), 64'hB);
      clear_errs();
      chk(status == 8'h03, "R11 final clear", 64'(status), 64'h03);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule